// File: doc/BRIEF.md
# Manchester Line Decoder with Bit-Clock Recovery

This block takes a single-wire bi-phase (Manchester) stream and rebuilds both the data bits and a bit-rate clock from it. It runs from a local clock that is a fixed multiple (16 or 32, set by a parameter) of the bit rate. The raw line is first passed through a two-stage synchroniser. After that, any change of level on the line, rising or falling, is treated as a transition. A gap meter measures the distance between successive transitions. A three-state machine uses that distance to separate the transitions at bit centres from the ones at bit boundaries.

When the machine accepts a bit-centre transition, it starts a one-shot of three quarters of a bit. Any further transition seen while the one-shot runs is a boundary transition and is skipped. When the one-shot expires, the synchronised line level holds the first half of the following bit. That level is turned into a data value according to the polarity parameter. Once eight consecutive samples have been taken without a fault, the decoder raises `locked`. From then on it reports every decoded bit with a one-cycle strobe and a recovered clock pulse. A gap that is too long or too short drops the lock and sets `sync_lost`.

States: HUNT (waiting for a full-bit gap), BLANK (one-shot running, boundary edges skipped), WAIT (one-shot expired, next edge taken as a bit centre). The transitions are: HUNT→BLANK on an edge closing a full-bit gap; BLANK→WAIT on one-shot expiry; WAIT→BLANK on any edge; BLANK or WAIT→HUNT on a short gap or a stale line.

Top module: `manch_rx`

## Requirements
- R1: `line_in` passes through two flip-flops before use. A change of the synchronised level in either direction counts as a transition.
- R2: In HUNT, only a transition that ends a gap of 3/4 to 3/2 of a bit period (OVS/4 quarters: 3Q to 6Q local clocks) starts tracking. A stream with no such gap (for example, all ones) never locks.
- R3: A centre transition starts a 3/4-bit one-shot (3·OVS/4 clocks). A transition that arrives during it, at least a quarter bit after the previous one, is ignored, so boundary transitions do not disturb decoding.
- R4: At one-shot expiry the synchronised level is the first half of the next bit. With POLARITY=0 a 1 is sent low-then-high, so a low sample decodes as 1. With POLARITY=1 a 1 is sent high-then-low, so a high sample decodes as 1.
- R5: Each reported bit appears on `data_out` with a `data_valid` pulse exactly one cycle wide. `rec_clk` pulses in the same cycle.
- R6: After acquisition, the first 8 one-shot samples are used only for locking. `locked` rises with the 8th, and only the 9th and later samples are reported.
- R7: When no transition is seen for more than 1.5 bit periods during tracking, the decoder drops `locked`, raises `sync_lost` and returns to HUNT.
- R8: When two transitions arrive less than a quarter bit apart during tracking, the decoder drops `locked`, raises `sync_lost` and returns to HUNT.
- R9: `sync_lost` stays high until the decoder locks again, and it clears in the same cycle that `locked` rises.
- R10: After reset `data_out`, `data_valid`, `rec_clk`, `locked` and `sync_lost` are all 0.
- R11: The same behaviour holds at OVS=16 and OVS=32, with all windows scaling with OVS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw bi-phase line, asynchronous to clk |
| data_out | output | 1 | Decoded bit, meaningful while data_valid is high |
| data_valid | output | 1 | One-cycle strobe per reported bit |
| rec_clk | output | 1 | Recovered bit clock pulse, coincident with data_valid |
| locked | output | 1 | High once the lock run has completed |
| sync_lost | output | 1 | High from a synchronisation fault until the next lock |

## Verification
The bench drives two instances at once: one with 16x oversampling and normal polarity, one with 32x and inverted polarity. Each gets an alternating preamble followed by pseudo-random data that contains runs, so boundary transitions are common. A decoder that took boundary edges as centres, or that mixed up the polarity, would produce a shifted or inverted stream. A decoder that reported too early or too late in the lock run would lose the alignment against the expected bit indices and the expected count.

After the stream ends, the line is held idle to trigger the stale timeout. A two-cycle glitch inside a locked stream must cause a short-gap loss, followed by a clean relock that clears `sync_lost`. A design that skipped either fault check would stay locked. A design that never cleared the flag would fail the relock check.

A run of all-ones bits offers only half-bit gaps. It must never lock, which catches a hunt that accepts the wrong spacing.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,
        S_BLANK = 2'd1,
        S_WAIT  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/manch_sync_edge.sv
module manch_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic edge_seen
);

    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= line_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign level     = stab_q;
    assign edge_seen = stab_q ^ prev_q;

endmodule

// File: rtl/manch_gap_meter.sv
module manch_gap_meter #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    output logic gap_short,
    output logic gap_full,
    output logic gap_stale
);

    localparam int Q   = OVS / 4;
    localparam int TOP = 2 * OVS;
    localparam int CW  = $clog2(TOP + 1);
    localparam logic [CW-1:0] LIM_SHORT = CW'(Q - 1);
    localparam logic [CW-1:0] LIM_FLO   = CW'(3 * Q - 1);
    localparam logic [CW-1:0] LIM_FHI   = CW'(6 * Q - 1);
    localparam logic [CW-1:0] LIM_STALE = CW'(6 * Q);
    localparam logic [CW-1:0] LIM_TOP   = CW'(TOP);

    // clocks elapsed since the last transition, minus one
    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= LIM_TOP;
        end else if (edge_seen) begin
            since_q <= '0;
        end else if (since_q != LIM_TOP) begin
            since_q <= since_q + 1'b1;
        end
    end

    assign gap_short = edge_seen && (since_q < LIM_SHORT);
    assign gap_full  = edge_seen && (since_q >= LIM_FLO) && (since_q <= LIM_FHI);
    assign gap_stale = (since_q >= LIM_STALE);

    p_gap_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(gap_short && gap_full));

    p_counter_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= LIM_TOP);

endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
    parameter int OVS       = 16,
    parameter bit POLARITY  = 1'b0,
    parameter int LOCK_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic data_out,
    output logic data_valid,
    output logic rec_clk,
    output logic locked,
    output logic sync_lost
);
    import manch_rx_pkg::*;

    localparam int T3Q = (3 * OVS) / 4;
    localparam int TW  = $clog2(T3Q + 1);
    localparam int LW  = $clog2(LOCK_BITS + 1);
    localparam logic [TW-1:0] TMR_LOAD = TW'(T3Q - 1);
    localparam logic [LW-1:0] LK_LAST  = LW'(LOCK_BITS - 1);

    logic level, edge_seen;
    logic gap_short, gap_full, gap_stale;

    manch_sync_edge u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .level     (level),
        .edge_seen (edge_seen)
    );

    manch_gap_meter #(.OVS(OVS)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_seen (edge_seen),
        .gap_short (gap_short),
        .gap_full  (gap_full),
        .gap_stale (gap_stale)
    );

    rx_state_t     state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic [LW-1:0] lk_q;
    logic          start, expire, lose, bit_dec;

    // next-state and event decode
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        expire  = 1'b0;
        lose    = 1'b0;
        unique case (state_q)
            S_HUNT: begin
                if (gap_full) begin
                    start   = 1'b1;
                    state_d = S_BLANK;
                end
            end
            S_BLANK: begin
                if (gap_short || gap_stale) begin
                    lose = 1'b1;
                end else if (tmr_q == '0) begin
                    expire  = 1'b1;
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (gap_short || gap_stale) begin
                    lose = 1'b1;
                end else if (edge_seen) begin
                    start   = 1'b1;
                    state_d = S_BLANK;
                end
            end
            default: lose = 1'b1;
        endcase
        if (lose) state_d = S_HUNT;
    end

    assign bit_dec = POLARITY ? level : ~level;

    // state register, one-shot and lock run counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_HUNT;
            tmr_q   <= '0;
            lk_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                tmr_q <= TMR_LOAD;
            end else if (state_q == S_BLANK && tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end
            if (lose) begin
                lk_q <= '0;
            end else if (expire && !locked && lk_q != LK_LAST) begin
                lk_q <= lk_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_out   <= 1'b0;
            data_valid <= 1'b0;
            rec_clk    <= 1'b0;
            locked     <= 1'b0;
            sync_lost  <= 1'b0;
        end else begin
            data_valid <= expire && locked;
            rec_clk    <= expire && locked;
            if (expire) data_out <= bit_dec;
            if (lose) begin
                locked    <= 1'b0;
                sync_lost <= 1'b1;
            end else if (expire && !locked && lk_q == LK_LAST) begin
                locked    <= 1'b1;
                sync_lost <= 1'b0;
            end
        end
    end

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);

    p_valid_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> locked);

    p_lost_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> !locked);

    p_hunt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) |=> !data_valid);

    p_timer_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BLANK) |-> (tmr_q <= TMR_LOAD));

endmodule

// File: tb/test_manch_rx.sv
module test_manch_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_v [2];
    logic dout [2], dv [2], rclk [2], lck [2], lost [2];

    always #5 clk = ~clk;

    manch_rx #(.OVS(16), .POLARITY(1'b0)) i_manch_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line_v[0]),
        .data_out(dout[0]), .data_valid(dv[0]), .rec_clk(rclk[0]),
        .locked(lck[0]), .sync_lost(lost[0]));

    manch_rx #(.OVS(32), .POLARITY(1'b1)) i_manch_rx_wide (
        .clk(clk), .rst_n(rst_n), .line_in(line_v[1]),
        .data_out(dout[1]), .data_valid(dv[1]), .rec_clk(rclk[1]),
        .locked(lck[1]), .sync_lost(lost[1]));

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    bit seq [2][64];
    bit rx  [2][128];
    int rxn [2];
    int rclk_bad [2];
    int lost_rise [2];
    logic lost_prev [2];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        for (int k = 0; k < 2; k++) begin
            if (rst_n) begin
                if (dv[k]) begin
                    if (rxn[k] < 128) rx[k][rxn[k]] = dout[k];
                    rxn[k]++;
                end
                if (rclk[k] !== dv[k]) rclk_bad[k]++;
                if (lost[k] && !lost_prev[k]) lost_rise[k]++;
                lost_prev[k] = lost[k];
            end
        end
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int ovs_of(input int k);
        return (k == 0) ? 16 : 32;
    endfunction

    function automatic bit first_half(input int k, input bit d);
        return (k == 0) ? ~d : d;  // R4: POLARITY 0 -> a 1 is low first
    endfunction

    task automatic send_bit(input int k, input bit d, input bit gl);
        int  o = ovs_of(k);
        bit  fh = first_half(k, d);
        for (int c = 0; c < o; c++) begin
            logic lv;
            @(negedge clk);
            lv = (c < o / 2) ? fh : ~fh;
            if (gl && (c == 2 || c == 3)) lv = ~lv;
            line_v[k] = lv;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // phase 1: preamble then pseudo-random payload, then idle line
    task automatic phase1(input int k);
        logic [15:0] lfsr = (k == 0) ? 16'hACE1 : 16'h3B71;
        for (int i = 0; i < 52; i++) begin
            if (i < 12) seq[k][i] = (i % 2 == 0);
            else if (i < 16) seq[k][i] = 1'b1;
            else begin
                seq[k][i] = lfsr[0];
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
        end
        line_v[k] = first_half(k, seq[k][0]);
        for (int i = 0; i < 52; i++) send_bit(k, seq[k][i], 1'b0);
        chk(lck[k] === 1'b1, "R6 locked after stream", lck[k], 1);
        idle(4 * ovs_of(k));
        chk(lost[k] === 1'b1, "R7 sync_lost after idle", lost[k], 1);
        chk(lck[k] === 1'b0, "R7 unlocked after idle", lck[k], 0);
    endtask

    // phase 2: lock, glitch, relock
    task automatic phase2(input int k);
        for (int i = 0; i < 22; i++) send_bit(k, (i % 2 == 0), 1'b0);
        chk(lck[k] === 1'b1 && lost[k] === 1'b0, "R9 relock clears sync_lost",
            {lck[k], lost[k]}, 2);
        lost_rise[k] = 0;
        send_bit(k, 1'b1, 1'b1);
        chk(lost[k] === 1'b1 && lck[k] === 1'b0, "R8 short gap drops lock",
            {lck[k], lost[k]}, 1);
        chk(lost_rise[k] == 1, "R8 one loss event", lost_rise[k], 1);
        for (int i = 0; i < 24; i++) send_bit(k, (i % 2 == 1), 1'b0);
        chk(lck[k] === 1'b1 && lost[k] === 1'b0, "R9 relock after glitch",
            {lck[k], lost[k]}, 2);
        idle(4 * ovs_of(k));
    endtask

    // phase 3: all ones gives only half-bit gaps
    task automatic phase3(input int k);
        int base = rxn[k];
        for (int i = 0; i < 30; i++) send_bit(k, 1'b1, 1'b0);
        chk(lck[k] === 1'b0, "R2 all-ones never locks", lck[k], 0);
        chk(rxn[k] == base, "R2 no bits reported while hunting", rxn[k] - base, 0);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            line_v[k] = 1'b0;
            rxn[k] = 0;
            rclk_bad[k] = 0;
            lost_rise[k] = 0;
            lost_prev[k] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk({dout[k], dv[k], rclk[k], lck[k], lost[k]} === 5'b0,
                "R10 reset outputs", {dout[k], dv[k], rclk[k], lck[k], lost[k]}, 0);
        end

        fork
            phase1(0);
            phase1(1);
        join
        for (int k = 0; k < 2; k++) begin
            // R6: samples of bits 2..9 lock, bits 10..52 reported (last is idle level)
            chk(rxn[k] == 43, "R6 reported count", rxn[k], 43);
            for (int i = 0; i < 42; i++) begin
                chk(rx[k][i] == seq[k][i + 10], "R3 R4 R11 decoded bit",
                    rx[k][i], seq[k][i + 10]);
            end
            chk(rclk_bad[k] == 0, "R5 rec_clk with data_valid", rclk_bad[k], 0);
        end

        fork
            phase2(0);
            phase2(1);
        join
        fork
            phase3(0);
            phase3(1);
        join
        for (int k = 0; k < 2; k++)
            chk(rclk_bad[k] == 0, "R1 R5 pulse pairing overall", rclk_bad[k], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule